// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block owns the instruction pointer of a small core whose code lives in one flat word address space. The low part of that space is a local register memory and everything above it is a larger shared memory. The PC value alone selects the fetch source, and no mode bit is involved. Each cycle the decoder presents at most one branch operation: jump, call, return or decrement-and-branch. A jump, call or return may use an absolute target, a relative offset, or both flags at once, which is a decode error. The block then forms the next PC, raises any side effect on the return-address storage, and updates its PC register.

A call saves the address of the following word. It writes that address either to one fixed local register (link mode) or to a stack as a push request (stack mode). A link-mode return is simply an indirect jump through the register value the decoder supplies. A stack-mode return raises a pop request and takes the popped word as the new PC. A separate start strobe launches a two-word constant load. That load occupies four clocks, holds the PC meanwhile and then steps over both words.

Top module: `pc_branch_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `pc` is 0, `stall` is 0 and no side-effect strobe (`link_we`, `push_req`, `pop_req`) is high with idle inputs.
- R2: With no branch taken and no load active, `pc` becomes `pc+1` at the next clock, wrapping from 0x1FFFF to 0.
- R3: `fetch_local` is 1 exactly when `pc` is below 0x200, and 0 from 0x200 upward.
- R4: `op` encodings are 0 none, 1 jump, 2 call, 3 return, 4 decrement-and-branch. An absolute jump or call (`abs_req`=1) loads `tgt_abs` into `pc` at the next clock.
- R5: A relative jump or call (`rel_req`=1, `abs_req`=0) loads `pc + tgt_rel` modulo 2^17.
- R6: If `abs_req` and `rel_req` are both 1 with a non-zero `op`, the relative request is rejected. In that cycle `decode_err` is 1 and the absolute target is used.
- R7: A taken call with `stk_mode`=0 raises `link_we` with `link_addr` = 0x1EF and `link_data` = `pc+1`, for both target forms.
- R8: A taken call with `stk_mode`=1 raises `push_req` with `push_data` = `pc+1`. Each push strobe stands for a one-step increment of the stack pointer. `link_we` stays 0.
- R9: A return with `stk_mode`=0 behaves as a jump through `tgt_abs` (or relative through `tgt_rel`). With `stk_mode`=1 it raises `pop_req` and `pc` becomes `pop_data`.
- R10: Decrement-and-branch in relative form adds the sign-extended 8-bit `disp` when `cond_nz`=1 and advances by one when `cond_nz`=0. The displacement 0x80 (-128) is out of range: it raises `decode_err` and the branch is not taken.
- R11: A `ldc_start` pulse holds `pc` for three clocks with `stall`=1 and then advances it by 2. Branch inputs during `stall` have no effect and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Branch operation code |
| abs_req | input | 1 | Absolute target form requested |
| rel_req | input | 1 | Relative target form requested |
| stk_mode | input | 1 | 0 link register, 1 stack for call/return |
| tgt_abs | input | 17 | Absolute target or register value |
| tgt_rel | input | 17 | Relative offset, full width |
| disp | input | 8 | Signed displacement for decrement-and-branch |
| cond_nz | input | 1 | Decremented count is non-zero |
| pop_data | input | 17 | Word returned by a stack pop |
| ldc_start | input | 1 | Start of a two-word constant load |
| pc | output | 17 | Current program counter |
| next_pc | output | 17 | Value loaded into the PC at the next edge |
| fetch_local | output | 1 | Fetch from local memory (1) or shared memory (0) |
| link_we | output | 1 | Return-address write to the link register |
| link_addr | output | 9 | Local address of the link register |
| link_data | output | 17 | Return address to write |
| push_req | output | 1 | Push return address, step stack pointer up |
| push_data | output | 17 | Return address to push |
| pop_req | output | 1 | Pop request for a stack return |
| stall | output | 1 | Constant load in progress |
| decode_err | output | 1 | Conflicting forms or displacement out of range |

## Verification
The embedded assertions watch, on every clock, the sequential step, the absolute-target load, the return address offered on a link write, the mutual exclusion of link write and push, the pop-to-PC transfer and the hold-then-skip-two pattern of the constant load. The directed scenarios are what show the address-map boundary at 0x1FF/0x200 and the wrap of relative targets past 0x1FFFF. They also cover the rejection of conflicting forms, the out-of-range displacement, and the silence of branch inputs during a stall, because those need chosen operand values and a known starting PC.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int PCU_PC_W = 17;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_JMP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_DJNZ = 3'd4
  } br_op_e;
endpackage

// File: rtl/pcu_target.sv
module pcu_target
  import pcu_pkg::*;
#(
  parameter int PC_W   = PCU_PC_W,
  parameter int DISP_W = 8
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [2:0]        op_i,
  input  logic              abs_req_i,
  input  logic              rel_req_i,
  input  logic              stk_mode_i,
  input  logic [PC_W-1:0]   tgt_abs_i,
  input  logic [PC_W-1:0]   tgt_rel_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              cond_nz_i,
  input  logic [PC_W-1:0]   pop_data_i,
  output logic              take_o,
  output logic [PC_W-1:0]   target_o,
  output logic              dec_err_o
);
  localparam logic [DISP_W-1:0] DISP_BAD = {1'b1, {(DISP_W-1){1'b0}}};

  function automatic logic [PC_W-1:0] add_wrap(input logic [PC_W-1:0] a,
                                              input logic [PC_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [PC_W-1:0] widen_disp(input logic [DISP_W-1:0] d);
    return {{(PC_W-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  br_op_e op;
  logic use_abs, use_rel, both_forms, disp_bad;
  logic [PC_W-1:0] form_tgt;

  assign op         = br_op_e'(op_i);
  assign use_abs    = abs_req_i;
  assign use_rel    = rel_req_i & ~abs_req_i;
  assign both_forms = abs_req_i & rel_req_i;
  assign disp_bad   = (disp_i == DISP_BAD);
  assign form_tgt   = use_abs ? tgt_abs_i : add_wrap(pc_i, tgt_rel_i);

  always_comb begin
    take_o    = 1'b0;
    target_o  = form_tgt;
    dec_err_o = both_forms && (op != OP_NONE);
    unique case (op)
      OP_JMP, OP_CALL: take_o = use_abs | use_rel;
      OP_RET: begin
        if (stk_mode_i) begin
          take_o   = 1'b1;
          target_o = pop_data_i;
        end else begin
          take_o   = use_abs | use_rel;
        end
      end
      OP_DJNZ: begin
        if (use_rel && disp_bad) begin
          dec_err_o = 1'b1;
        end else begin
          take_o   = cond_nz_i & (use_abs | use_rel);
          target_o = use_abs ? tgt_abs_i : add_wrap(pc_i, widen_disp(disp_i));
        end
      end
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcu_link.sv
module pcu_link
  import pcu_pkg::*;
#(
  parameter int PC_W = PCU_PC_W
) (
  input  logic            en_i,
  input  logic            take_i,
  input  logic [2:0]      op_i,
  input  logic            stk_mode_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            link_we_o,
  output logic            push_req_o,
  output logic            pop_req_o,
  output logic [PC_W-1:0] ret_addr_o
);
  logic is_call, is_ret;

  assign is_call    = en_i && take_i && (br_op_e'(op_i) == OP_CALL);
  assign is_ret     = en_i && (br_op_e'(op_i) == OP_RET);
  assign link_we_o  = is_call & ~stk_mode_i;
  assign push_req_o = is_call & stk_mode_i;
  assign pop_req_o  = is_ret & stk_mode_i;
  assign ret_addr_o = pc_i + 1'b1;
endmodule

// File: rtl/pcu_const_seq.sv
module pcu_const_seq #(
  parameter int LDC_CLOCKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic advance_o
);
  localparam int CNT_W = $clog2(LDC_CLOCKS);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LDC_CLOCKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
    else if (start_i)           cnt_q <= CNT_LOAD;
  end

  assign busy_o    = (cnt_q != '0);
  assign advance_o = (cnt_q == CNT_W'(1));

  assert_busy_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && cnt_q == CNT_LOAD));
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcu_pkg::*;
#(
  parameter int PC_W        = PCU_PC_W,
  parameter int DISP_W      = 8,
  parameter int LOCAL_WORDS = 512,
  parameter int LINK_REG    = 'h1EF,
  parameter int LDC_CLOCKS  = 4,
  parameter int LDC_WORDS   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [2:0]                     op,
  input  logic                           abs_req,
  input  logic                           rel_req,
  input  logic                           stk_mode,
  input  logic [PC_W-1:0]                tgt_abs,
  input  logic [PC_W-1:0]                tgt_rel,
  input  logic [DISP_W-1:0]              disp,
  input  logic                           cond_nz,
  input  logic [PC_W-1:0]                pop_data,
  input  logic                           ldc_start,
  output logic [PC_W-1:0]                pc,
  output logic [PC_W-1:0]                next_pc,
  output logic                           fetch_local,
  output logic                           link_we,
  output logic [$clog2(LOCAL_WORDS)-1:0] link_addr,
  output logic [PC_W-1:0]                link_data,
  output logic                           push_req,
  output logic [PC_W-1:0]                push_data,
  output logic                           pop_req,
  output logic                           stall,
  output logic                           decode_err
);
  localparam int LA_W = $clog2(LOCAL_WORDS);

  logic [PC_W-1:0] pc_q, target, ret_addr;
  logic take, dec_err, busy, advance, en;

  pcu_const_seq #(.LDC_CLOCKS(LDC_CLOCKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(ldc_start),
    .busy_o(busy), .advance_o(advance)
  );

  assign en = ~busy & ~ldc_start;

  pcu_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
    .pc_i(pc_q), .op_i(op), .abs_req_i(abs_req), .rel_req_i(rel_req),
    .stk_mode_i(stk_mode), .tgt_abs_i(tgt_abs), .tgt_rel_i(tgt_rel),
    .disp_i(disp), .cond_nz_i(cond_nz), .pop_data_i(pop_data),
    .take_o(take), .target_o(target), .dec_err_o(dec_err)
  );

  pcu_link #(.PC_W(PC_W)) u_link (
    .en_i(en), .take_i(take), .op_i(op), .stk_mode_i(stk_mode), .pc_i(pc_q),
    .link_we_o(link_we), .push_req_o(push_req), .pop_req_o(pop_req),
    .ret_addr_o(ret_addr)
  );

  always_comb begin
    if (advance)          next_pc = pc_q + PC_W'(LDC_WORDS);
    else if (!en)         next_pc = pc_q;
    else if (take)        next_pc = target;
    else                  next_pc = pc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= next_pc;
  end

  assign pc          = pc_q;
  assign fetch_local = (pc_q < PC_W'(LOCAL_WORDS));
  assign link_addr   = LA_W'(LINK_REG);
  assign link_data   = ret_addr;
  assign push_data   = ret_addr;
  assign stall       = busy;
  assign decode_err  = en & dec_err;

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !take) |=> pc_q == PC_W'($past(pc_q) + 1'b1));
  assert_abs_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && take && abs_req && (op == OP_JMP || op == OP_CALL)) |=> pc_q == $past(tgt_abs));
  assert_link_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_data == PC_W'(pc_q + 1'b1));
  assert_one_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_we && push_req));
  assert_pop_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |=> pc_q == $past(pop_data));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !advance) |=> pc_q == $past(pc_q));
  assert_skip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> pc_q == PC_W'($past(pc_q) + LDC_WORDS));
  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(link_we || push_req || pop_req || decode_err));
endmodule

// File: tb/sim_pc_branch_unit.sv
module sim_pc_branch_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op;
  logic abs_req, rel_req, stk_mode, cond_nz, ldc_start;
  logic [16:0] tgt_abs, tgt_rel, pop_data;
  logic [7:0] disp;
  logic [16:0] pc, next_pc, link_data, push_data;
  logic [8:0] link_addr;
  logic fetch_local, link_we, push_req, pop_req, stall, decode_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pc_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .op(op), .abs_req(abs_req), .rel_req(rel_req),
    .stk_mode(stk_mode), .tgt_abs(tgt_abs), .tgt_rel(tgt_rel), .disp(disp),
    .cond_nz(cond_nz), .pop_data(pop_data), .ldc_start(ldc_start),
    .pc(pc), .next_pc(next_pc), .fetch_local(fetch_local), .link_we(link_we),
    .link_addr(link_addr), .link_data(link_data), .push_req(push_req),
    .push_data(push_data), .pop_req(pop_req), .stall(stall), .decode_err(decode_err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    op = 3'd0; abs_req = 0; rel_req = 0; stk_mode = 0; cond_nz = 0;
    ldc_start = 0; tgt_abs = '0; tgt_rel = '0; pop_data = '0; disp = '0;
  endtask

  // drive at negedge, let combinational outputs settle, then cross one edge
  task automatic settle(); #1; endtask
  task automatic edge_pass(); @(negedge clk); endtask

  task automatic go_abs(input logic [16:0] a);
    idle(); op = 3'd1; abs_req = 1; edge_pass(); idle();
  endtask

  task automatic t_reset();
    idle();
    repeat (3) @(negedge clk);
    check("R1", "pc in reset", pc, 0);
    check("R1", "stall in reset", stall, 0);
    check("R1", "strobes in reset", {link_we, push_req, pop_req}, 0);
    rst_n = 1;
    settle();
    check("R1", "pc after release", pc, 0);
  endtask

  task automatic t_seq();
    repeat (3) edge_pass();
    check("R2", "three steps", pc, 3);
    settle();
    check("R2", "next_pc", next_pc, 4);
  endtask

  task automatic t_map();
    idle(); op = 3'd1; abs_req = 1; tgt_abs = 17'h1FF; edge_pass(); idle();
    check("R4", "abs jump", pc, 17'h1FF);
    check("R3", "local at 0x1FF", fetch_local, 1);
    edge_pass();
    check("R3", "shared at 0x200", fetch_local, 0);
    check("R2", "step to 0x200", pc, 17'h200);
  endtask

  task automatic t_wrap();
    idle(); op = 3'd1; abs_req = 1; tgt_abs = 17'h1FFFF; edge_pass(); idle();
    edge_pass();
    check("R2", "wrap to zero", pc, 0);
  endtask

  task automatic t_rel();
    idle(); op = 3'd1; rel_req = 1; tgt_rel = 17'h1FFF0; settle();
    check("R6", "no error single form", decode_err, 0);
    edge_pass();
    check("R5", "negative rel", pc, 17'h1FFF0);
    idle(); op = 3'd2; rel_req = 1; stk_mode = 1; tgt_rel = 17'h20; edge_pass(); idle();
    check("R5", "rel wraps past top", pc, 17'h10);
  endtask

  task automatic t_both();
    idle(); op = 3'd1; abs_req = 1; rel_req = 1; tgt_abs = 17'h55; tgt_rel = 17'h7;
    settle();
    check("R6", "decode_err", decode_err, 1);
    edge_pass(); idle();
    check("R6", "abs wins", pc, 17'h55);
  endtask

  task automatic t_call_link();
    idle(); op = 3'd1; abs_req = 1; tgt_abs = 17'h300; edge_pass();
    idle(); op = 3'd2; abs_req = 1; tgt_abs = 17'h40; settle();
    check("R7", "link_we", link_we, 1);
    check("R7", "link_addr", link_addr, 9'h1EF);
    check("R7", "link_data", link_data, 17'h301);
    check("R8", "no push in link mode", push_req, 0);
    edge_pass();
    check("R7", "call target", pc, 17'h40);
    idle(); op = 3'd2; rel_req = 1; tgt_rel = 17'h10; settle();
    check("R7", "rel call link_data", link_data, 17'h41);
    edge_pass(); idle();
    check("R7", "rel call target", pc, 17'h50);
  endtask

  task automatic t_call_stack();
    idle(); op = 3'd2; abs_req = 1; stk_mode = 1; tgt_abs = 17'h900; settle();
    check("R8", "push_req", push_req, 1);
    check("R8", "push_data", push_data, 17'h51);
    check("R8", "no link write", link_we, 0);
    edge_pass(); idle();
    check("R8", "call target", pc, 17'h900);
  endtask

  task automatic t_ret();
    idle(); op = 3'd3; abs_req = 1; tgt_abs = 17'h51; settle();
    check("R9", "no pop in link mode", pop_req, 0);
    edge_pass();
    check("R9", "link return", pc, 17'h51);
    idle(); op = 3'd3; stk_mode = 1; pop_data = 17'h1234; settle();
    check("R9", "pop_req", pop_req, 1);
    edge_pass(); idle();
    check("R9", "stack return", pc, 17'h1234);
  endtask

  task automatic t_djnz();
    idle(); op = 3'd4; rel_req = 1; cond_nz = 1; disp = 8'hFD; edge_pass();
    check("R10", "taken back", pc, 17'h1231);
    cond_nz = 0; edge_pass();
    check("R10", "not taken", pc, 17'h1232);
    cond_nz = 1; disp = 8'h80; settle();
    check("R10", "bad disp error", decode_err, 1);
    edge_pass();
    check("R10", "bad disp not taken", pc, 17'h1233);
    disp = 8'h7F; edge_pass(); idle();
    check("R10", "max forward", pc, 17'h12B2);
  endtask

  task automatic t_ldc();
    idle(); ldc_start = 1; edge_pass(); idle();
    check("R11", "held at start", pc, 17'h12B2);
    for (int i = 0; i < 3; i++) begin
      op = 3'd2; abs_req = 1; tgt_abs = 17'h777; settle();
      check("R11", "stall high", stall, 1);
      check("R11", "no strobe in stall", {link_we, push_req, pop_req}, 0);
      edge_pass();
      check("R11", "pc during load", pc, (i < 2) ? 17'h12B2 : 17'h12B4);
    end
    idle(); settle();
    check("R11", "stall released", stall, 0);
  endtask

  initial begin
    idle();
    t_reset();
    t_seq();
    t_map();
    t_wrap();
    t_rel();
    t_both();
    t_call_link();
    t_call_stack();
    t_ret();
    t_djnz();
    t_ldc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule